// File: doc/BRIEF.md
# Two-Dimensional and Ring DMA Address Sequencer

This block generates the word addresses for one DMA channel. Software, or a channel controller, presents a start word address, a line length, a line count and a line pitch, then pulses a start strobe. The sequencer then offers one word address per beat on a valid/ready stream. The data mover downstream consumes each address when it can, and back-pressure from `addr_ready_i` holds the sequence at its current word. All lengths and the pitch are counted in 32-bit words.

When the line length is nonzero, the walk covers `ylen_i + 1` lines. Each line has `xlen_i` consecutive words, and each line starts `width_i` words after the one before it. A single-cycle done pulse follows the handshake of the last word. When the line length is zero, the block instead runs a ring over `width_i * (ylen_i + 1)` words. The ring never finishes on its own. It raises an event pulse each time the walk leaves either half of the ring. A stop strobe cancels either kind of run at once.

Top module: `dma2d_addr_gen`

## Requirements
- R1: After reset, busy_o, addr_valid_o, done_o and half_o are all 0.
- R2: A start pulse while idle, with xlen_i nonzero, makes busy_o and addr_valid_o high on the next cycle. The words are then offered in order: address base + line*width + col, with col running 0..xlen-1 inside each line and line running 0..ylen.
- R3: done_o is high for exactly the cycle after the handshake of the final word of a line walk. In that same cycle busy_o and addr_valid_o are already 0.
- R4: A start with xlen_i equal to 0 selects ring mode. The offered address is base + off. off starts at 0, rises by 1 per handshake and returns to 0 after area-1, where area = width*(ylen+1). done_o never rises in ring mode.
- R5: In ring mode, half_o pulses in the cycle after the handshake of the word at offset half-1, and again after the word at offset area-1, where half = floor(area/2). With area 1 there is only the wrap event.
- R6: done_o and half_o are single-cycle pulses, and half_o only occurs while busy_o is high.
- R7: A stop pulse while busy drops busy_o and addr_valid_o on the next cycle, with no done_o or half_o, even if a handshake happens in that same cycle. A stop pulse while idle has no effect.
- R8: While addr_valid_o is high and addr_ready_i is low, addr_o holds its value and the sequence does not advance.
- R9: A start pulse while busy is ignored, and so is a start pulse in the same cycle as stop. The running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start strobe; captures the configuration when idle |
| stop_i | input | 1 | Abort strobe |
| base_i | input | AW | Start word address |
| xlen_i | input | LW | Words per line; 0 selects ring mode |
| ylen_i | input | LW | Line count minus one |
| width_i | input | LW | Line pitch in words |
| busy_o | output | 1 | Channel running |
| addr_valid_o | output | 1 | Address stream valid |
| addr_ready_i | input | 1 | Address stream ready from the consumer |
| addr_o | output | AW | Current word address |
| done_o | output | 1 | Line walk finished pulse |
| half_o | output | 1 | Ring half-boundary pulse |

## Verification
Every result is registered exactly once. The first address and busy appear one cycle after the start edge. done_o and half_o appear one cycle after the handshake that produced them, and the drop after stop also comes one cycle later. The bench drives inputs and samples outputs on the falling edge. Each falling edge first compares done_o and half_o against the expectation that the previous handshake set up, and only then evaluates the current beat, so no expected value is read from the edge that creates it. Back-pressure is checked by comparing the held address on the falling edge that follows a stalled beat.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LINE = 2'd1,
    ST_RING = 2'd2
  } dma2d_state_e;

  function automatic int unsigned area_bits(input int unsigned lw);
    return 2 * lw + 1;
  endfunction

endpackage

// File: rtl/dma2d_cfg_reg.sv
module dma2d_cfg_reg #(
  parameter int AW     = 32,
  parameter int LW     = 16,
  parameter int AREA_W = 2 * LW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [AW-1:0]     base_in,
  input  logic [LW-1:0]     xlen_in,
  input  logic [LW-1:0]     ylen_in,
  input  logic [LW-1:0]     width_in,
  output logic [AW-1:0]     base_q,
  output logic [LW-1:0]     xlen_q,
  output logic [LW-1:0]     ylen_q,
  output logic [LW-1:0]     width_q,
  output logic [AREA_W-1:0] area_q,
  output logic [AREA_W-1:0] half_q
);

  logic [AREA_W-1:0] area_d;

  // ring size in words: pitch times number of lines
  always_comb begin
    area_d = AREA_W'(width_in) * (AREA_W'(ylen_in) + AREA_W'(1));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q  <= '0;
      xlen_q  <= '0;
      ylen_q  <= '0;
      width_q <= '0;
      area_q  <= '0;
    end else if (load) begin
      base_q  <= base_in;
      xlen_q  <= xlen_in;
      ylen_q  <= ylen_in;
      width_q <= width_in;
      area_q  <= area_d;
    end
  end

  // first-half boundary rounds down for odd ring sizes
  assign half_q = area_q >> 1;

endmodule

// File: rtl/dma2d_line_walk.sv
module dma2d_line_walk #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  logic [AW-1:0] base_in,
  input  logic [LW-1:0] xlen,
  input  logic [LW-1:0] ylen,
  input  logic [LW-1:0] width,
  output logic [AW-1:0] addr,
  output logic          last
);

  logic [LW-1:0] col_q;
  logic [LW-1:0] line_q;
  logic [AW-1:0] line_base_q;
  logic          end_of_line;
  logic          end_of_walk;

  assign end_of_line = (col_q == xlen - LW'(1));
  assign end_of_walk = (line_q == ylen);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q       <= '0;
      line_q      <= '0;
      line_base_q <= '0;
    end else if (clear) begin
      col_q       <= '0;
      line_q      <= '0;
      line_base_q <= base_in;
    end else if (step) begin
      if (end_of_line) begin
        col_q       <= '0;
        line_q      <= line_q + LW'(1);
        line_base_q <= line_base_q + AW'(width);
      end else begin
        col_q <= col_q + LW'(1);
      end
    end
  end

  assign addr = line_base_q + AW'(col_q);
  assign last = end_of_line & end_of_walk;

endmodule

// File: rtl/dma2d_ring_walk.sv
module dma2d_ring_walk #(
  parameter int AREA_W = 33
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic [AREA_W-1:0] area,
  input  logic [AREA_W-1:0] half,
  output logic [AREA_W-1:0] off,
  output logic              boundary
);

  logic [AREA_W-1:0] off_q;
  logic [AREA_W-1:0] off_nxt;
  logic              at_wrap;
  logic              at_half;

  assign off_nxt = off_q + AREA_W'(1);
  assign at_wrap = (off_nxt == area);
  assign at_half = (off_nxt == half);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      off_q <= '0;
    end else if (clear) begin
      off_q <= '0;
    end else if (step) begin
      off_q <= at_wrap ? '0 : off_nxt;
    end
  end

  assign off      = off_q;
  assign boundary = at_wrap | at_half;

endmodule

// File: rtl/dma2d_addr_gen.sv
module dma2d_addr_gen #(
  parameter int AW = 32,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          stop_i,
  input  logic [AW-1:0] base_i,
  input  logic [LW-1:0] xlen_i,
  input  logic [LW-1:0] ylen_i,
  input  logic [LW-1:0] width_i,
  output logic          busy_o,
  output logic          addr_valid_o,
  input  logic          addr_ready_i,
  output logic [AW-1:0] addr_o,
  output logic          done_o,
  output logic          half_o
);
  import dma2d_pkg::*;

  localparam int AREA_W = 2 * LW + 1;

  dma2d_state_e      state_q;
  logic              load;
  logic              fire;
  logic              step_line;
  logic              step_ring;
  logic              line_last;
  logic              ring_bnd;
  logic              done_q;
  logic              half_q;
  logic [AW-1:0]     base_q;
  logic [LW-1:0]     xlen_q;
  logic [LW-1:0]     ylen_q;
  logic [LW-1:0]     width_q;
  logic [AREA_W-1:0] area_q;
  logic [AREA_W-1:0] half_sz;
  logic [AREA_W-1:0] ring_off;
  logic [AW-1:0]     line_addr;

  assign load      = (state_q == ST_IDLE) & start_i & ~stop_i;
  assign fire      = addr_valid_o & addr_ready_i;
  assign step_line = fire & ~stop_i & (state_q == ST_LINE);
  assign step_ring = fire & ~stop_i & (state_q == ST_RING);

  dma2d_cfg_reg #(.AW(AW), .LW(LW), .AREA_W(AREA_W)) cfg_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .base_in  (base_i),
    .xlen_in  (xlen_i),
    .ylen_in  (ylen_i),
    .width_in (width_i),
    .base_q   (base_q),
    .xlen_q   (xlen_q),
    .ylen_q   (ylen_q),
    .width_q  (width_q),
    .area_q   (area_q),
    .half_q   (half_sz)
  );

  dma2d_line_walk #(.AW(AW), .LW(LW)) line_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (load),
    .step    (step_line),
    .base_in (base_i),
    .xlen    (xlen_q),
    .ylen    (ylen_q),
    .width   (width_q),
    .addr    (line_addr),
    .last    (line_last)
  );

  dma2d_ring_walk #(.AREA_W(AREA_W)) ring_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (load),
    .step     (step_ring),
    .area     (area_q),
    .half     (half_sz),
    .off      (ring_off),
    .boundary (ring_bnd)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      half_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      half_q <= 1'b0;
      if (stop_i) begin
        state_q <= ST_IDLE;
      end else begin
        case (state_q)
          ST_IDLE: if (start_i) state_q <= (xlen_i == '0) ? ST_RING : ST_LINE;
          ST_LINE: if (fire && line_last) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
          ST_RING: if (fire && ring_bnd) half_q <= 1'b1;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign busy_o       = (state_q != ST_IDLE);
  assign addr_valid_o = busy_o;
  assign addr_o       = (state_q == ST_RING) ? base_q + AW'(ring_off) : line_addr;
  assign done_o       = done_q;
  assign half_o       = half_q;

endmodule

// File: rtl/dma2d_addr_gen_chk.sv
module dma2d_addr_gen_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic          stop_i,
  input logic          busy_o,
  input logic          addr_valid_o,
  input logic          addr_ready_i,
  input logic [AW-1:0] addr_o,
  input logic          done_o,
  input logic          half_o
);

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (!busy_o && !addr_valid_o && !done_o && !half_o));

  assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !addr_valid_o));

  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_half_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    half_o |-> busy_o);

  assert_stop_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_i && busy_o) |=> (!busy_o && !addr_valid_o && !done_o && !half_o));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid_o && !addr_ready_i && !stop_i) |=> (addr_valid_o && $stable(addr_o)));

  assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && !stop_i && !addr_ready_i) |=> (busy_o && $stable(addr_o)));

endmodule

bind dma2d_addr_gen dma2d_addr_gen_chk #(.AW(AW)) chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .start_i      (start_i),
  .stop_i       (stop_i),
  .busy_o       (busy_o),
  .addr_valid_o (addr_valid_o),
  .addr_ready_i (addr_ready_i),
  .addr_o       (addr_o),
  .done_o       (done_o),
  .half_o       (half_o)
);

// File: tb/dma2d_addr_gen_tb.sv
module dma2d_addr_gen_tb_top;
  localparam int AW = 32;
  localparam int LW = 16;

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] xlen;
    logic [15:0] ylen;
    logic [15:0] width;
    logic [15:0] stop_after;
    logic [15:0] restart_at;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{32'h0000_0100, 16'd4, 16'd2, 16'd6, 16'd0,  16'd0},
    '{32'h0000_2000, 16'd1, 16'd0, 16'd1, 16'd0,  16'd0},
    '{32'h0000_0040, 16'd3, 16'd1, 16'd3, 16'd0,  16'd0},
    '{32'h0000_0500, 16'd0, 16'd3, 16'd2, 16'd20, 16'd0},
    '{32'h0000_0900, 16'd0, 16'd0, 16'd3, 16'd9,  16'd0},
    '{32'h0000_3000, 16'd4, 16'd3, 16'd4, 16'd5,  16'd0},
    '{32'h0000_7000, 16'd2, 16'd2, 16'd5, 16'd0,  16'd2}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          stop_i = 1'b0;
  logic [AW-1:0] base_i = '0;
  logic [LW-1:0] xlen_i = '0;
  logic [LW-1:0] ylen_i = '0;
  logic [LW-1:0] width_i = '0;
  logic          addr_ready_i = 1'b0;
  logic          busy_o;
  logic          addr_valid_o;
  logic [AW-1:0] addr_o;
  logic          done_o;
  logic          half_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  dma2d_addr_gen #(.AW(AW), .LW(LW)) dut_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .stop_i       (stop_i),
    .base_i       (base_i),
    .xlen_i       (xlen_i),
    .ylen_i       (ylen_i),
    .width_i      (width_i),
    .busy_o       (busy_o),
    .addr_valid_o (addr_valid_o),
    .addr_ready_i (addr_ready_i),
    .addr_o       (addr_o),
    .done_o       (done_o),
    .half_o       (half_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v);
    int unsigned line = 0, col = 0, off = 0, beats = 0, cyc = 0;
    int unsigned area, half;
    bit ring, exp_done = 0, exp_half = 0, hold = 0, restarted = 0;
    logic [AW-1:0] hold_addr = '0, exp_addr;
    ring = (v.xlen == 0);
    area = v.width * (v.ylen + 1);
    half = area / 2;
    base_i = v.base; xlen_i = v.xlen; ylen_i = v.ylen; width_i = v.width;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2", "busy after start", busy_o, 1);
    chk("R2", "valid after start", addr_valid_o, 1);
    while (cyc < 2000) begin
      chk(ring ? "R4" : "R3", "done pulse", done_o, exp_done);
      chk("R5", "half event", half_o, exp_half);
      if (exp_done) begin
        chk("R3", "busy after done", busy_o, 0);
        chk("R3", "valid after done", addr_valid_o, 0);
        @(negedge clk);
        chk("R6", "done single cycle", done_o, 0);
        break;
      end
      exp_done = 0; exp_half = 0;
      if (hold) chk("R8", "addr held under stall", addr_o, hold_addr);
      if (v.stop_after != 0 && beats == v.stop_after) begin
        stop_i = 1'b1; addr_ready_i = 1'b0; start_i = 1'b0;
        @(negedge clk);
        stop_i = 1'b0;
        chk("R7", "busy after stop", busy_o, 0);
        chk("R7", "valid after stop", addr_valid_o, 0);
        chk("R7", "no done on stop", done_o, 0);
        chk("R7", "no half on stop", half_o, 0);
        repeat (3) begin
          @(negedge clk);
          chk("R7", "no late done", done_o, 0);
        end
        break;
      end
      addr_ready_i = (cyc % 3) != 2;
      if (v.restart_at != 0 && beats == v.restart_at && !restarted) begin
        start_i = 1'b1; base_i = v.base + 32'h1000; xlen_i = 16'd7; restarted = 1;
      end else begin
        start_i = 1'b0;
      end
      if (addr_valid_o) begin
        if (ring) exp_addr = v.base + off;
        else      exp_addr = v.base + line * v.width + col;
        if (addr_ready_i) begin
          chk(ring ? "R4" : (restarted ? "R9" : "R2"), "address", addr_o, exp_addr);
          beats++;
          hold = 0;
          if (ring) begin
            exp_half = ((off + 1) == half) || ((off + 1) == area);
            off = ((off + 1) == area) ? 0 : off + 1;
          end else begin
            col++;
            if (col == v.xlen) begin
              col = 0;
              line++;
              if (line > v.ylen) exp_done = 1;
            end
          end
        end else begin
          hold = 1;
          hold_addr = addr_o;
        end
      end else begin
        chk("R2", "valid while running", addr_valid_o, 1);
      end
      @(negedge clk);
      cyc++;
    end
    addr_ready_i = 1'b0;
    start_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL WDOG run did not finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "busy in reset", busy_o, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", busy_o, 0);
    chk("R1", "valid after reset", addr_valid_o, 0);
    chk("R1", "done after reset", done_o, 0);
    chk("R1", "half after reset", half_o, 0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // stop while idle has no effect
    stop_i = 1'b1;
    @(negedge clk);
    stop_i = 1'b0;
    chk("R7", "idle stop busy", busy_o, 0);
    chk("R7", "idle stop done", done_o, 0);

    // start together with stop is ignored
    base_i = 32'h10; xlen_i = 16'd2; ylen_i = 16'd0; width_i = 16'd2;
    start_i = 1'b1; stop_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; stop_i = 1'b0;
    chk("R9", "start with stop busy", busy_o, 0);
    chk("R9", "start with stop valid", addr_valid_o, 0);

    // plain start afterwards still works, held under stall
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk("R2", "first address", addr_o, 32'h10);
    @(negedge clk);
    chk("R8", "stalled address", addr_o, 32'h10);
    addr_ready_i = 1'b1;
    @(negedge clk);
    chk("R2", "second address", addr_o, 32'h11);
    @(negedge clk);
    addr_ready_i = 1'b0;
    chk("R3", "done after short walk", done_o, 1);
    @(negedge clk);
    chk("R6", "done drops", done_o, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule